// File: doc/BRIEF.md
# Symbol Timing Drift Loop Filter

This block sits between an OFDM symbol timing estimator and a fractional resampler. Each time the estimator reports where the current symbol starts within the 2560-sample symbol period, the block subtracts the previous report. It folds the result into a signed step of at most half a symbol. It then smooths these per-symbol steps with a first-order exponential filter. The smoothed value is the average drift of the FFT window in samples per symbol. It is proportional to the sample clock offset: one sample per symbol corresponds to 12 kHz, and 0.05 samples per symbol to 600 Hz.

The filtered drift is converted into a per-sample fractional delay increment. The increment is the negated drift divided by the 2560-sample symbol length. The resampler adds it to its delay accumulator at every sample. The increment is held at zero, and the valid flag low, until enough differences have been averaged for the estimate to be meaningful.

Top module: `sco_drift_loop`

## Requirements
- R1: After reset, `drift_rate` and `delay_step` are zero and `step_valid` is low.
- R2: The first `tim_strobe` after reset only records `tim_index` as the previous index. It forms no difference and leaves `drift_rate` at zero.
- R3: Every later strobe forms d = index − previous index and folds it into the range [−1280, 1279]. A raw value of 1280 or more has 2560 subtracted; a raw value below −1280 has 2560 added. The new index then becomes the previous index.
- R4: On each difference, the accumulator A (signed, 16 fraction bits, reset 0) becomes A + ((d·2^16 − A) >>> 3), where >>> is an arithmetic shift that rounds toward minus infinity. `drift_rate` shows A two clock cycles after the strobe cycle.
- R5: `drift_rate` does not change in cycles that bring no new difference.
- R6: `step_valid` rises three cycles after the strobe that delivers the 8th difference since reset. It then stays high until reset. While it is low, `delay_step` is zero.
- R7: While valid, `delay_step` equals −((A·1677722) >>> 16). This is the step in units of 2^−32 sample, with 1677722 = round(2^32/2560). It is updated three cycles after the strobe.
- R8: The step is clamped to the signed 32-bit range [−2^31, 2^31−1]. A drift held at −1280 samples per symbol yields 2^31−1.
- R9: While valid, a positive drift gives a step of zero or below, and a negative drift gives a step of zero or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tim_strobe | input | 1 | One-cycle pulse: a new symbol timing index is present |
| tim_index | input | 12 | Symbol start position, 0 to 2559 |
| drift_rate | output | 29 | Signed average drift, samples per symbol, 16 fraction bits |
| delay_step | output | 32 | Signed per-sample delay increment, 2^−32 sample units |
| step_valid | output | 1 | Averaging has warmed up; step is usable |

## Verification
The block is a three-register pipeline. The difference is registered on the edge that samples the strobe, the filtered drift one edge later, and the scaled step and valid flag one edge after that. The bench therefore drives the strobe for a single cycle and compares `drift_rate` at the second falling edge after the strobe edge. It compares `delay_step` and `step_valid` at the third. In the idle cycles between strobes it checks that the drift holds. Expected values come from an integer model of the folding, the shift filter, the warm-up count and the clamped scaling.

// File: rtl/sco_drift_pkg.sv
package sco_drift_pkg;
    localparam int SCO_SYM_LEN  = 2560;
    localparam int SCO_IDX_W    = 12;
    localparam int SCO_FRAC_W   = 16;
    localparam int SCO_ALPHA_SH = 3;
    localparam int SCO_WARMUP   = 8;
    localparam int SCO_STEP_W   = 32;
    localparam int SCO_RSH      = 16;
endpackage

// File: rtl/sco_wrap_diff.sv
module sco_wrap_diff
    import sco_drift_pkg::*;
#(
    parameter int SYM_LEN = SCO_SYM_LEN,
    parameter int IDX_W   = SCO_IDX_W,
    parameter int DIFF_W  = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic [IDX_W-1:0]         index,
    output logic                     diff_vld,
    output logic signed [DIFF_W-1:0] diff
);
    localparam int RAW_W = DIFF_W + 1;
    localparam logic signed [RAW_W-1:0] HALF_POS = RAW_W'(SYM_LEN / 2);
    localparam logic signed [RAW_W-1:0] HALF_NEG = -RAW_W'(SYM_LEN / 2);
    localparam logic signed [RAW_W-1:0] PERIOD   = RAW_W'(SYM_LEN);

    typedef struct packed {
        logic                     armed;
        logic [IDX_W-1:0]         prev;
        logic                     vld;
        logic signed [DIFF_W-1:0] diff;
    } wrap_st_t;

    wrap_st_t st_d, st_q;
    logic signed [RAW_W-1:0] raw;
    logic signed [RAW_W-1:0] folded;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        raw      = $signed({2'b00, index}) - $signed({2'b00, st_q.prev});
        if (raw >= HALF_POS) begin
            folded = raw - PERIOD;
        end else if (raw < HALF_NEG) begin
            folded = raw + PERIOD;
        end else begin
            folded = raw;
        end
        if (strobe) begin
            st_d.prev  = index;
            st_d.armed = 1'b1;
            if (st_q.armed) begin
                st_d.vld  = 1'b1;
                st_d.diff = folded[DIFF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign diff_vld = st_q.vld;
    assign diff     = st_q.diff;
endmodule

// File: rtl/sco_drift_iir.sv
module sco_drift_iir
    import sco_drift_pkg::*;
#(
    parameter int DIFF_W   = SCO_IDX_W + 1,
    parameter int FRAC_W   = SCO_FRAC_W,
    parameter int ALPHA_SH = SCO_ALPHA_SH,
    parameter int WARMUP   = SCO_WARMUP,
    parameter int ACC_W    = DIFF_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     diff_vld,
    input  logic signed [DIFF_W-1:0] diff,
    output logic signed [ACC_W-1:0]  acc,
    output logic                     warm
);
    localparam int CNT_W = $clog2(WARMUP + 1);
    localparam int ERR_W = ACC_W + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WARMUP);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [CNT_W-1:0]        cnt;
    } iir_st_t;

    iir_st_t st_d, st_q;
    logic signed [ERR_W-1:0] target;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] nudge;
    logic signed [ERR_W-1:0] sum;

    always_comb begin
        st_d   = st_q;
        target = ERR_W'(diff) <<< FRAC_W;
        err    = target - ERR_W'(st_q.acc);
        nudge  = err >>> ALPHA_SH;
        sum    = ERR_W'(st_q.acc) + nudge;
        if (diff_vld) begin
            st_d.acc = sum[ACC_W-1:0];
            if (st_q.cnt != CNT_TOP) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc  = st_q.acc;
    assign warm = (st_q.cnt == CNT_TOP);
endmodule

// File: rtl/sco_step_scale.sv
module sco_step_scale
    import sco_drift_pkg::*;
#(
    parameter int SYM_LEN = SCO_SYM_LEN,
    parameter int FRAC_W  = SCO_FRAC_W,
    parameter int RSH     = SCO_RSH,
    parameter int ACC_W   = SCO_IDX_W + 1 + SCO_FRAC_W,
    parameter int STEP_W  = SCO_STEP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [ACC_W-1:0]  acc,
    input  logic                     warm,
    output logic signed [STEP_W-1:0] step,
    output logic                     valid
);
    localparam int     RECIP_W = FRAC_W + RSH + 1;
    localparam longint RECIP_L = ((64'sd1 <<< (FRAC_W + RSH)) + longint'(SYM_LEN / 2)) / longint'(SYM_LEN);
    localparam int     PROD_W  = ACC_W + RECIP_W;
    localparam logic signed [RECIP_W-1:0] RECIP    = RECIP_W'(RECIP_L);
    localparam logic signed [PROD_W-1:0]  STEP_MAX = PROD_W'((64'sd1 <<< (STEP_W - 1)) - 64'sd1);
    localparam logic signed [PROD_W-1:0]  STEP_MIN = -PROD_W'(64'sd1 <<< (STEP_W - 1));

    typedef struct packed {
        logic signed [STEP_W-1:0] step;
        logic                     valid;
    } scale_st_t;

    scale_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] negated;
    logic signed [STEP_W-1:0] clamped;

    always_comb begin
        prod    = PROD_W'(acc) * PROD_W'(RECIP);
        scaled  = prod >>> RSH;
        negated = -scaled;
        if (negated > STEP_MAX) begin
            clamped = STEP_MAX[STEP_W-1:0];
        end else if (negated < STEP_MIN) begin
            clamped = STEP_MIN[STEP_W-1:0];
        end else begin
            clamped = negated[STEP_W-1:0];
        end
        st_d.valid = warm;
        st_d.step  = warm ? clamped : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step  = st_q.step;
    assign valid = st_q.valid;
endmodule

// File: rtl/sco_drift_loop.sv
module sco_drift_loop
    import sco_drift_pkg::*;
#(
    parameter int SYM_LEN  = SCO_SYM_LEN,
    parameter int IDX_W    = SCO_IDX_W,
    parameter int FRAC_W   = SCO_FRAC_W,
    parameter int ALPHA_SH = SCO_ALPHA_SH,
    parameter int WARMUP   = SCO_WARMUP,
    parameter int STEP_W   = SCO_STEP_W,
    parameter int RSH      = SCO_RSH,
    parameter int DIFF_W   = IDX_W + 1,
    parameter int ACC_W    = DIFF_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tim_strobe,
    input  logic [IDX_W-1:0]         tim_index,
    output logic signed [ACC_W-1:0]  drift_rate,
    output logic signed [STEP_W-1:0] delay_step,
    output logic                     step_valid
);
    logic                     diff_vld;
    logic signed [DIFF_W-1:0] diff_val;
    logic                     warm;

    sco_wrap_diff #(
        .SYM_LEN (SYM_LEN),
        .IDX_W   (IDX_W),
        .DIFF_W  (DIFF_W)
    ) u_diff (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (tim_strobe),
        .index    (tim_index),
        .diff_vld (diff_vld),
        .diff     (diff_val)
    );

    sco_drift_iir #(
        .DIFF_W   (DIFF_W),
        .FRAC_W   (FRAC_W),
        .ALPHA_SH (ALPHA_SH),
        .WARMUP   (WARMUP),
        .ACC_W    (ACC_W)
    ) u_iir (
        .clk      (clk),
        .rst_n    (rst_n),
        .diff_vld (diff_vld),
        .diff     (diff_val),
        .acc      (drift_rate),
        .warm     (warm)
    );

    sco_step_scale #(
        .SYM_LEN (SYM_LEN),
        .FRAC_W  (FRAC_W),
        .RSH     (RSH),
        .ACC_W   (ACC_W),
        .STEP_W  (STEP_W)
    ) u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (drift_rate),
        .warm  (warm),
        .step  (delay_step),
        .valid (step_valid)
    );
endmodule

// File: rtl/sco_drift_loop_chk.sv
module sco_drift_loop_chk #(
    parameter int SYM_LEN = 2560,
    parameter int DIFF_W  = 13,
    parameter int ACC_W   = 29,
    parameter int STEP_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     diff_vld,
    input logic signed [DIFF_W-1:0] diff_val,
    input logic signed [ACC_W-1:0]  drift_rate,
    input logic signed [STEP_W-1:0] delay_step,
    input logic                     step_valid
);
    localparam logic signed [DIFF_W-1:0] LIM_HI = DIFF_W'(SYM_LEN / 2 - 1);
    localparam logic signed [DIFF_W-1:0] LIM_LO = -DIFF_W'(SYM_LEN / 2);

    assert_diff_folded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        diff_vld |-> (diff_val <= LIM_HI && diff_val >= LIM_LO));

    assert_drift_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !diff_vld |=> $stable(drift_rate));

    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> step_valid);

    assert_zero_when_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |-> delay_step == '0);

    assert_sign_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && $past(drift_rate) > 0) |-> delay_step <= 0);

    assert_sign_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && $past(drift_rate) < 0) |-> delay_step >= 0);
endmodule

bind sco_drift_loop sco_drift_loop_chk #(
    .SYM_LEN (SYM_LEN),
    .DIFF_W  (DIFF_W),
    .ACC_W   (ACC_W),
    .STEP_W  (STEP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .diff_vld   (diff_vld),
    .diff_val   (diff_val),
    .drift_rate (drift_rate),
    .delay_step (delay_step),
    .step_valid (step_valid)
);

// File: tb/sco_drift_loop_bench.sv
module sco_drift_loop_bench;
    localparam int     CLK_PERIOD = 10;
    localparam int     SEED       = 1234;
    localparam longint RECIP      = 1677722;
    localparam longint SMAX       = 64'sd2147483647;
    localparam longint SMIN       = -64'sd2147483648;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tim_strobe = 1'b0;
    logic [11:0]        tim_index = '0;
    logic signed [28:0] drift_rate;
    logic signed [31:0] delay_step;
    logic               step_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit     m_armed;
    int     m_prev;
    longint m_acc;
    int     m_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sco_drift_loop u_sco_drift_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .tim_strobe (tim_strobe),
        .tim_index  (tim_index),
        .drift_rate (drift_rate),
        .delay_step (delay_step),
        .step_valid (step_valid)
    );

    function automatic int fold(int raw);
        if (raw >= 1280) return raw - 2560;
        if (raw < -1280) return raw + 2560;
        return raw;
    endfunction

    function automatic longint step_of(longint acc);
        longint v;
        v = -((acc * RECIP) >>> 16);
        if (v > SMAX) v = SMAX;
        if (v < SMIN) v = SMIN;
        return v;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tim_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_armed = 1'b0;
        m_prev = 0;
        m_acc = 0;
        m_cnt = 0;
        @(negedge clk);
        chk("R1", "drift_rate", longint'(drift_rate), 0);
        chk("R1", "delay_step", longint'(delay_step), 0);
        chk("R1", "step_valid", longint'(step_valid), 0);
    endtask

    task automatic send(int idx, int gap, string req);
        bit     valid_exp;
        longint step_exp;
        @(negedge clk);
        tim_strobe = 1'b1;
        tim_index = 12'(idx);
        if (!m_armed) begin
            m_armed = 1'b1;
        end else begin
            m_acc = m_acc + (((longint'(fold(idx - m_prev))) <<< 16) - m_acc >>> 3);
            if (m_cnt < 8) m_cnt++;
        end
        m_prev = idx;
        valid_exp = (m_cnt >= 8);
        step_exp = valid_exp ? step_of(m_acc) : 0;
        @(negedge clk);
        tim_strobe = 1'b0;
        @(negedge clk);
        chk(req, "drift_rate", longint'(drift_rate), m_acc);
        @(negedge clk);
        chk(req, "delay_step", longint'(delay_step), step_exp);
        chk("R6", "step_valid", longint'(step_valid), longint'(valid_exp));
        if (gap > 0) begin
            repeat (gap) @(negedge clk);
            chk("R5", "drift_rate idle", longint'(drift_rate), m_acc);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int idx;
        void'($urandom(SEED));
        do_reset();

        // R2: first strobe only records the index
        send(700, 2, "R2");
        chk("R2", "step_valid after first", longint'(step_valid), 0);

        // R3: wrap at the period edge, forward and backward
        send(2559, 0, "R3");
        send(1, 0, "R3");
        send(2558, 0, "R3");
        send(1279 + 2558 - 2560, 0, "R3");

        // R4/R6/R7/R9: random drift around a mean, with jitter
        idx = 1277;
        for (int seg = 0; seg < 4; seg++) begin
            int mean = int'($urandom_range(6)) - 3;
            for (int k = 0; k < 15; k++) begin
                int d = mean + ((($urandom_range(3)) == 0) ? 1 : 0);
                idx = (idx + d + 2560) % 2560;
                send(idx, int'($urandom_range(3)), "R7");
            end
        end
        chk("R6", "valid held", longint'(step_valid), 1);

        // R9: positive drift gives a non-positive step
        for (int k = 0; k < 40; k++) begin
            idx = (idx + 5) % 2560;
            send(idx, 0, "R4");
        end
        checks++;
        if (!(delay_step < 0)) begin
            failures++;
            $display("FAIL R9 step sign actual=%0d expected=<0", delay_step);
        end

        // R8: drift pinned at -1280 saturates the step
        do_reset();
        for (int k = 0; k < 170; k++) begin
            send(((k % 2) == 0) ? 0 : 1280, 0, "R8");
        end
        chk("R8", "saturated step", longint'(delay_step), SMAX);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule